// File: doc/BRIEF.md
# Registered-Handshake Slave Wait Controller

This block sits between a memory-mapped bus master and a slow device that needs several clocks to complete each access. All of the master's request inputs (read strobe, write strobe, address, write data) go through a bank of capture flip-flops before the controller sees them. The wait signal back to the master is also driven straight from a flip-flop. Because both paths are registered, a wait line that idled low could let two commands through before the controller could react. The controller avoids this by holding wait high at all times and opening it for a single clock per command.

When a registered request shows up while the controller is idle, the wait flip-flop drops for exactly one cycle, and the master's command is taken on that clock edge. The captured command is then handed to the back end as a one-cycle start pulse with its direction, address and data. The controller keeps wait high until the back end signals done. For a read, the returned word is presented to the master for one cycle, together with a valid strobe. A write returns nothing.

Top module: `slow_slave_front`

## Requirements
- R1: While reset is asserted and afterwards with no request pending, `bus_wait` is 1, `bus_rvalid` is 0 and `be_start` is 0.
- R2: From idle, a request first driven before clock edge E1 sees `bus_wait` fall after edge E2 (one register for the request, one for wait).
- R3: `bus_wait` is low for exactly one cycle per accepted command, and it stays high from that acceptance until the command has completed.
- R4: Each accepted command produces exactly one one-cycle `be_start` pulse, two clocks after the acceptance edge. The pulse carries the accepted direction (`be_is_write` = 1 for write), address and write data.
- R5: No new `be_start` is issued while a started command has not yet seen `be_done`.
- R6: For a read, `bus_rvalid` is high for one cycle, in the cycle right after the cycle in which `be_done` was high. `bus_rdata` equals the `be_rdata` value presented with that done.
- R7: A write never produces `bus_rvalid`.
- R8: If read and write are both asserted in the same request, the command is treated as a write.
- R9: Commands presented back to back, with no idle cycle between them, are each accepted once. They reach the back end in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Master read request |
| bus_wr | input | 1 | Master write request |
| bus_addr | input | AW | Master address |
| bus_wdata | input | DW | Master write data |
| bus_wait | output | 1 | Registered wait; low for one cycle to accept a command |
| bus_rdata | output | DW | Read data to master |
| bus_rvalid | output | 1 | One-cycle read data valid |
| be_start | output | 1 | One-cycle command start to back end |
| be_is_write | output | 1 | Direction of started command (1 = write) |
| be_addr | output | AW | Address of started command |
| be_wdata | output | DW | Write data of started command |
| be_done | input | 1 | Back end completion pulse |
| be_rdata | input | DW | Back end read data, valid with done |

## Verification
The controller is driven with isolated reads and writes after idle gaps, which expose the two-register request-to-wait latency. It is also driven with back-to-back commands that keep a request asserted across the return to idle; these separate a correct single acceptance from a double one. A request with both strobes set distinguishes write priority from read priority. The back-end model varies its latency from one cycle to twenty. This shows whether wait stays high for the whole of a long access and whether read data is tied to the done cycle and not to a fixed delay.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE_WAIT = 2'd0,
    ST_ACCEPT    = 2'd1,
    ST_BUSY      = 2'd2,
    ST_RESPOND   = 2'd3
  } swc_state_e;

  // Direction resolution: a write request wins over a read request.
  function automatic logic swc_resolve_write(input logic rd, input logic wr);
    return wr | (wr & rd);
  endfunction

  // Next-state computation of the handshake controller.
  function automatic swc_state_e swc_next(input swc_state_e cur,
                                          input logic req,
                                          input logic taken,
                                          input logic is_wr);
    swc_state_e nxt;
    nxt = cur;
    case (cur)
      ST_IDLE_WAIT: if (req) nxt = ST_ACCEPT;
      ST_ACCEPT:    nxt = ST_BUSY;
      ST_BUSY:      if (taken) nxt = is_wr ? ST_IDLE_WAIT : ST_RESPOND;
      ST_RESPOND:   nxt = ST_IDLE_WAIT;
      default:      nxt = ST_IDLE_WAIT;
    endcase
    return nxt;
  endfunction

  // Wait is released only on the idle-to-accept transition.
  function automatic logic swc_wait_next(input swc_state_e cur, input swc_state_e nxt);
    return !((cur == ST_IDLE_WAIT) && (nxt == ST_ACCEPT));
  endfunction

endpackage

// File: rtl/swc_in_regs.sv
module swc_in_regs #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rd_q,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q    <= rd_i;
      wr_q    <= wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_q,
  input  logic          wr_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic          be_done,
  output logic          wait_o,
  output logic          start_o,
  output logic          is_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          accept_o,
  output logic          take_o
);

  swc_state_e    state, state_nxt;
  logic          wait_q;
  logic          issued;
  logic          start_q;
  logic          hold_wr;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_wdata;
  logic          req;
  logic          load;
  logic          taken;

  assign req   = rd_q | wr_q;
  assign load  = (state == ST_BUSY) && !issued;
  assign taken = (state == ST_BUSY) && issued && !start_q && be_done;

  always_comb state_nxt = swc_next(state, req, taken, hold_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE_WAIT;
      wait_q <= 1'b1;
    end else begin
      state  <= state_nxt;
      wait_q <= swc_wait_next(state, state_nxt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued  <= 1'b0;
      start_q <= 1'b0;
    end else if (state == ST_ACCEPT) begin
      issued  <= 1'b0;
      start_q <= 1'b0;
    end else if (load) begin
      issued  <= 1'b1;
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_wr    <= 1'b0;
      hold_addr  <= '0;
      hold_wdata <= '0;
    end else if (load) begin
      hold_wr    <= swc_resolve_write(rd_q, wr_q);
      hold_addr  <= addr_q;
      hold_wdata <= wdata_q;
    end
  end

  assign wait_o   = wait_q;
  assign start_o  = start_q;
  assign is_wr_o  = hold_wr;
  assign addr_o   = hold_addr;
  assign wdata_o  = hold_wdata;
  assign accept_o = (state == ST_ACCEPT);
  assign take_o   = taken;

endmodule

// File: rtl/swc_resp.sv
module swc_resp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          is_wr_i,
  input  logic [DW-1:0] be_rdata,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= take_i && !is_wr_i;
      if (take_i && !is_wr_i) rdata_o <= be_rdata;
    end
  end

endmodule

// File: rtl/slow_slave_front.sv
module slow_slave_front #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_wait,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          be_start,
  output logic          be_is_write,
  output logic [AW-1:0] be_addr,
  output logic [DW-1:0] be_wdata,
  input  logic          be_done,
  input  logic [DW-1:0] be_rdata
);

  logic          rd_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          ev_accept;
  logic          ev_take;

  swc_in_regs #(.AW(AW), .DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n),
    .rd_i(bus_rd), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .rd_q(rd_q), .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  swc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_q(rd_q), .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .be_done(be_done),
    .wait_o(bus_wait), .start_o(be_start), .is_wr_o(be_is_write),
    .addr_o(be_addr), .wdata_o(be_wdata),
    .accept_o(ev_accept), .take_o(ev_take)
  );

  swc_resp #(.DW(DW)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .take_i(ev_take), .is_wr_i(be_is_write), .be_rdata(be_rdata),
    .rvalid_o(bus_rvalid), .rdata_o(bus_rdata)
  );

endmodule

// File: rtl/swc_chk.sv
module swc_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_wait,
  input logic bus_rvalid,
  input logic be_start,
  input logic be_is_write,
  input logic be_done,
  input logic ev_accept
);

  logic pend;
  logic last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      last_wr <= 1'b0;
    end else if (be_start) begin
      pend    <= 1'b1;
      last_wr <= be_is_write;
    end else if (be_done) begin
      pend    <= 1'b0;
    end
  end

  // R3
  accept_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wait |=> bus_wait);

  // R3
  wait_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> bus_wait);

  // R3
  accept_has_open_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !bus_wait);

  // R4
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |=> !be_start);

  // R4
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> $past(ev_accept, 2));

  // R5
  no_overlap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> !pend);

  // R6
  rvalid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(be_done));

  // R6
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |=> !bus_rvalid);

  // R7
  no_write_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> !last_wr);

endmodule

bind slow_slave_front swc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wait(bus_wait), .bus_rvalid(bus_rvalid),
  .be_start(be_start), .be_is_write(be_is_write), .be_done(be_done),
  .ev_accept(ev_accept)
);

// File: tb/tb_slow_slave_front.sv
module tb_slow_slave_front;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wait, bus_rvalid, be_start, be_is_write;
  logic [DW-1:0] bus_rdata, be_wdata;
  logic [AW-1:0] be_addr;
  logic          be_done = 1'b0;
  logic [DW-1:0] be_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int n_cmd = 0, n_reads = 0;
  int n_acc = 0, n_waitlow = 0, n_start = 0, n_rvalid = 0;
  int acc_age = 100;
  int lat_sel = 0;
  int force_lat = 0;
  bit busy_flag = 0, dev_pend = 0, prev_done = 0, done_mon = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] dev_mem [DEPTH];
  logic [DW-1:0] exp_rd_q [$];
  logic [AW+DW:0] exp_cmd_q [$];

  always #10 clk = ~clk;

  slow_slave_front #(.AW(AW), .DW(DW)) dut (.*);

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 16'h1111) ^ DW'(16'h00A5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: called at a negedge; holds request until accepted.
  task automatic do_cmd(input bit rd, input bit wr, input int a, input int d, input bit chk_lat);
    int cnt;
    logic [AW-1:0] aa;
    aa = AW'(a);
    bus_rd = rd; bus_wr = wr; bus_addr = aa; bus_wdata = DW'(d);
    cnt = 0;
    while (bus_wait) begin @(negedge clk); cnt++; end
    if (chk_lat) check(cnt == 2, "R2 idle request-to-wait latency", cnt, 2);
    n_cmd++;
    if (wr) begin
      exp_cmd_q.push_back({1'b1, aa, DW'(d)});
      ref_mem[aa] = DW'(d);
    end else begin
      exp_cmd_q.push_back({1'b0, aa, DW'(0)});
      exp_rd_q.push_back(ref_mem[aa]);
      n_reads++;
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // Back-end model with variable latency.
  initial begin
    forever begin
      @(negedge clk);
      if (be_start) begin
        logic [AW+DW:0] e;
        int lat;
        if (exp_cmd_q.size() == 0) begin
          check(0, "R4 unexpected start", 1, 0);
        end else begin
          e = exp_cmd_q.pop_front();
          // R4 R8 direction, address and data of started command
          check(be_is_write == e[AW+DW], "R8 start direction", be_is_write, e[AW+DW]);
          check(be_addr == e[AW+DW-1:DW], "R4 start address", be_addr, e[AW+DW-1:DW]);
          if (e[AW+DW]) check(be_wdata == e[DW-1:0], "R4 start wdata", be_wdata, e[DW-1:0]);
        end
        lat = (force_lat != 0) ? force_lat : 1 + (lat_sel * 3) % 6;
        lat_sel++;
        repeat (lat) @(negedge clk);
        be_rdata = dev_mem[be_addr];
        if (be_is_write) dev_mem[be_addr] = be_wdata;
        be_done = 1'b1;
        @(negedge clk);
        be_done = 1'b0;
        be_rdata = '0;
      end
    end
  end

  // Monitor / scoreboard, sampled after the inputs settle at the negedge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        acc_age++;
        if (!bus_wait) begin
          n_waitlow++;
          // R3 wait must not open while a command is in flight
          if (busy_flag) check(0, "R3 wait low while busy", 0, 1);
        end
        if (be_start) begin
          n_start++;
          // R4 two clocks after acceptance
          check(acc_age == 2, "R4 start timing after accept", acc_age, 2);
          // R5 no start while one is outstanding
          check(!dev_pend, "R5 start while pending", 1, 0);
          dev_pend = 1;
        end
        if (bus_rvalid) begin
          n_rvalid++;
          // R6 valid immediately follows done
          check(prev_done, "R6 rvalid one cycle after done", 0, 1);
          if (exp_rd_q.size() == 0) check(0, "R7 unexpected rvalid", 1, 0);
          else begin
            logic [DW-1:0] ex;
            ex = exp_rd_q.pop_front();
            check(bus_rdata == ex, "R6 read data", bus_rdata, ex);
          end
          busy_flag = 0;
        end
        done_mon = be_done;
        if (be_done) begin
          dev_pend = 0;
          if (be_is_write) busy_flag = 0;
        end
        if ((bus_rd || bus_wr) && !bus_wait) begin
          n_acc++;
          acc_age = 0;
          busy_flag = 1;
        end
        prev_done = done_mon;
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = init_word(i);
      dev_mem[i] = init_word(i);
    end
    fork
      begin
        repeat (4) begin
          @(negedge clk);
          // R1 reset state
          check(bus_wait && !bus_rvalid && !be_start, "R1 reset outputs",
                {bus_wait, bus_rvalid, be_start}, 3'b100);
        end
        rst_n = 1'b1;
        repeat (4) begin
          @(negedge clk);
          // R1 idle with no request
          check(bus_wait && !bus_rvalid && !be_start, "R1 idle outputs",
                {bus_wait, bus_rvalid, be_start}, 3'b100);
        end
        do_cmd(0, 1, 3, 16'h1234, 1);
        repeat (12) @(negedge clk);
        do_cmd(1, 0, 3, 0, 1);
        repeat (12) @(negedge clk);
        do_cmd(1, 0, 5, 0, 1);
        repeat (12) @(negedge clk);
        // R9 back-to-back commands
        do_cmd(0, 1, 7, 16'hBEEF, 0);
        do_cmd(1, 0, 7, 0, 0);
        do_cmd(1, 0, 3, 0, 0);
        do_cmd(0, 1, 0, 16'h0F0F, 0);
        do_cmd(1, 0, 0, 0, 0);
        repeat (12) @(negedge clk);
        // R8 both strobes: treated as write
        do_cmd(1, 1, 9, 16'hCAFE, 1);
        do_cmd(1, 0, 9, 0, 0);
        repeat (12) @(negedge clk);
        // long back-end latency
        force_lat = 20;
        do_cmd(1, 0, 15, 0, 0);
        do_cmd(0, 1, 15, 16'h5A5A, 0);
        do_cmd(1, 0, 15, 0, 0);
        force_lat = 0;
        repeat (40) @(negedge clk);
        // R3 one open-wait cycle per command; R9 each accepted once
        check(n_waitlow == n_cmd, "R3 wait-low cycles per command", n_waitlow, n_cmd);
        check(n_acc == n_cmd, "R9 acceptances", n_acc, n_cmd);
        check(n_start == n_cmd, "R4 start count", n_start, n_cmd);
        // R7 responses only for reads
        check(n_rvalid == n_reads, "R7 response count", n_rvalid, n_reads);
        check(exp_rd_q.size() == 0 && exp_cmd_q.size() == 0, "R9 queues drained",
              exp_rd_q.size() + exp_cmd_q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule